// File: doc/BRIEF.md
# Load Resistance Estimation Sequencer

This block runs beside the level controller of a multilevel converter current loop. On every control tick it compares the size of the current tracking error (measured current minus reference) against the ripple the loop is expected to produce. The expected ripple is supplied as an input value, already computed from the level step, the loop rate and the load inductance. When the error is clearly too large, meaning more than 1.3 times the expected ripple, the block concludes that the load resistance has drifted and starts a short measurement episode.

During an episode the block raises a flag that forces the commanded output level to zero for eight ticks, so the load current decays freely. It captures five consecutive current samples from that decay. From those samples it accumulates the two least-squares sums that a downstream divider needs to fit the decay factor: the sum of neighbouring sample products and the sum of squared samples. At the end it pulses a done strobe with the sums valid, and normal level control resumes. A hold-off window then keeps a single disturbance from starting back-to-back episodes.

Top module: `load_res_est_seq`

## Requirements
- R1: After reset `busy`, `lvl_force_zero` and `done` are low and both sums read zero.
- R2: A tick on which |i_meas − i_ref| × 10 > ripple_exp × 13, while idle and outside hold-off, starts an episode: `busy` and `lvl_force_zero` are high in the cycle after that tick.
- R3: An error magnitude of exactly 1.3 × ripple_exp, or less, does not start an episode.
- R4: Once started, `busy` and `lvl_force_zero` stay high through exactly eight further ticks, however many clock cycles separate them, and both fall in the cycle after the eighth tick.
- R5: The samples i0..i4 are the `i_meas` values on episode ticks 2 to 6 (tick 1 is the first tick after the starting tick). `sum_xy` = i0·i1 + i1·i2 + i2·i3 + i3·i4, signed two's complement.
- R6: `sum_xx` = i0² + i1² + i2² + i3², signed two's complement. The sums are cleared when an episode starts and hold their value until the next one starts.
- R7: `done` is high for exactly one cycle, the cycle after the eighth tick, and the sums are valid in that cycle.
- R8: The trigger condition is ignored while an episode is running: it neither restarts nor lengthens the episode, nor clears the sums.
- R9: The trigger condition is ignored on the 16 ticks that follow the end of an episode. The 17th tick can start a new episode.
- R10: Without a tick nothing advances: a large error with `tick` low starts no episode.
- R11: The error magnitude is absolute, so a measured current below the reference by more than 1.3 × ripple_exp also triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle control-loop tick |
| i_meas | input | W | Measured load current, signed |
| i_ref | input | W | Reference current, signed |
| ripple_exp | input | W | Expected peak-to-peak ripple, unsigned |
| lvl_force_zero | output | 1 | Forces the commanded level to zero |
| busy | output | 1 | Measurement episode in progress |
| done | output | 1 | One-cycle strobe: sums valid |
| sum_xy | output | 2W+GUARD | Sum of neighbouring sample products |
| sum_xx | output | 2W+GUARD | Sum of squared samples |

## Verification
The bench probes the trigger at the exact 1.3 boundary from both signs of the error. A design that used ≥ instead of >, or that dropped the absolute value, would start, or fail to start, an episode there. It spaces ticks apart and checks that the episode length counts ticks, not clocks, and that the capture window sits on ticks 2 to 6. A design with the window off by one gives sums built from the wrong samples. It keeps the error large through an episode and over exactly 16 and 17 following ticks. A design that restarts mid-episode, or that gets the hold-off count wrong by one, is exposed by an early or missing rise of `busy`.

// File: rtl/lres_pkg.sv
package lres_pkg;

    // Trigger ratio: error must exceed ripple * TRIG_NUM / TRIG_DEN
    localparam int TRIG_NUM = 13;
    localparam int TRIG_DEN = 10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lres_state_e;

    // capture strobe handed from the episode controller to the accumulator
    typedef struct packed {
        logic en;     // sample present on this tick
        logic first;  // first sample of the episode (no product yet)
    } cap_evt_t;

    function automatic logic in_window(input int idx, input int lo, input int hi);
        return (idx >= lo) && (idx <= hi);
    endfunction

endpackage

// File: rtl/lres_err_detect.sv
module lres_err_detect
    import lres_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] i_meas,
    input  logic signed [W-1:0] i_ref,
    input  logic        [W-1:0] ripple_exp,
    output logic                exceed
);
    localparam int DW = W + 1;
    localparam int LW = W + 6;

    logic signed [DW-1:0] diff;
    logic        [DW-1:0] mag;
    logic        [LW-1:0] lhs;
    logic        [LW-1:0] rhs;

    always_comb begin
        diff = DW'(i_meas) - DW'(i_ref);
        mag  = diff[DW-1] ? DW'(-diff) : DW'(diff);
        lhs  = LW'(mag) * LW'(TRIG_DEN);
        rhs  = LW'(ripple_exp) * LW'(TRIG_NUM);
        exceed = lhs > rhs;
    end

endmodule

// File: rtl/lres_episode_ctrl.sv
module lres_episode_ctrl
    import lres_pkg::*;
#(
    parameter int EP_TICKS  = 8,
    parameter int CAP_FIRST = 2,
    parameter int NSAMP     = 5,
    parameter int HOLDOFF   = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     exceed,
    output logic     start,
    output logic     busy,
    output logic     done,
    output cap_evt_t cap
);
    localparam int NW = $clog2(EP_TICKS + 1);
    localparam int HW = $clog2(HOLDOFF + 1);
    localparam int CAP_LAST = CAP_FIRST + NSAMP - 1;

    lres_state_e    state;
    logic [NW-1:0]  nt;
    logic [HW-1:0]  hold;
    int             nxt;

    always_comb begin
        nxt       = int'(nt) + 1;
        start     = (state == ST_IDLE) && tick && (hold == '0) && exceed;
        cap.en    = (state == ST_RUN) && tick && in_window(nxt, CAP_FIRST, CAP_LAST);
        cap.first = nxt == CAP_FIRST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            nt    <= '0;
            hold  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        nt    <= '0;
                    end else if (tick && hold != '0) begin
                        hold <= hold - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (nxt == EP_TICKS) begin
                            state <= ST_IDLE;
                            nt    <= '0;
                            hold  <= HW'(HOLDOFF);
                            done  <= 1'b1;
                        end else begin
                            nt <= NW'(nxt);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = state == ST_RUN;

endmodule

// File: rtl/lres_sample_mac.sv
module lres_sample_mac
    import lres_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 34
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  cap_evt_t             cap,
    input  logic signed [W-1:0]  x,
    output logic signed [SW-1:0] sum_xy,
    output logic signed [SW-1:0] sum_xx
);
    localparam int PW = 2 * W;

    logic signed [W-1:0]  prev;
    logic signed [PW-1:0] p_xy;
    logic signed [PW-1:0] p_xx;
    logic signed [SW-1:0] e_xy;
    logic signed [SW-1:0] e_xx;

    always_comb begin
        p_xy = prev * x;
        p_xx = prev * prev;
        e_xy = {{(SW-PW){p_xy[PW-1]}}, p_xy};
        e_xx = {{(SW-PW){p_xx[PW-1]}}, p_xx};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            sum_xy <= '0;
            sum_xx <= '0;
        end else if (clear) begin
            prev   <= '0;
            sum_xy <= '0;
            sum_xx <= '0;
        end else if (cap.en) begin
            prev <= x;
            if (!cap.first) begin
                sum_xy <= sum_xy + e_xy;
                sum_xx <= sum_xx + e_xx;
            end
        end
    end

endmodule

// File: rtl/load_res_est_seq.sv
module load_res_est_seq
    import lres_pkg::*;
#(
    parameter int W         = 16,
    parameter int GUARD     = 2,
    parameter int EP_TICKS  = 8,
    parameter int CAP_FIRST = 2,
    parameter int NSAMP     = 5,
    parameter int HOLDOFF   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         tick,
    input  logic signed [W-1:0]          i_meas,
    input  logic signed [W-1:0]          i_ref,
    input  logic        [W-1:0]          ripple_exp,
    output logic                         lvl_force_zero,
    output logic                         busy,
    output logic                         done,
    output logic signed [2*W+GUARD-1:0]  sum_xy,
    output logic signed [2*W+GUARD-1:0]  sum_xx
);
    localparam int SW = 2 * W + GUARD;

    logic     exceed;
    logic     start;
    logic     run;
    cap_evt_t cap;

    lres_err_detect #(.W(W)) u_det (
        .i_meas    (i_meas),
        .i_ref     (i_ref),
        .ripple_exp(ripple_exp),
        .exceed    (exceed)
    );

    lres_episode_ctrl #(
        .EP_TICKS (EP_TICKS),
        .CAP_FIRST(CAP_FIRST),
        .NSAMP    (NSAMP),
        .HOLDOFF  (HOLDOFF)
    ) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .exceed(exceed),
        .start (start),
        .busy  (run),
        .done  (done),
        .cap   (cap)
    );

    lres_sample_mac #(.W(W), .SW(SW)) u_mac (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .cap   (cap),
        .x     (i_meas),
        .sum_xy(sum_xy),
        .sum_xx(sum_xx)
    );

    assign busy           = run;
    assign lvl_force_zero = run;

endmodule

// File: rtl/lres_chk.sv
module lres_chk #(
    parameter int SW      = 34,
    parameter int HOLDOFF = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          busy,
    input logic          lvl_force_zero,
    input logic          done,
    input logic [SW-1:0] sum_xy,
    input logic [SW-1:0] sum_xx
);
    localparam int CW = $clog2(HOLDOFF + 2) + 1;
    logic [CW-1:0] since;

    // ticks seen since the last done strobe, saturating above the hold-off
    always_ff @(posedge clk) begin
        if (rst) since <= CW'(HOLDOFF + 1);
        else if (done) since <= tick ? CW'(1) : CW'(0);
        else if (tick && since <= CW'(HOLDOFF)) since <= since + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !busy && !done && sum_xy == '0);
    a_r2_start_on_tick: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(tick));
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst) busy && !tick |=> busy);
    a_r4_force_follows: assert property (@(posedge clk) disable iff (rst) $fell(lvl_force_zero) |-> done);
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst) done |-> !busy && $past(busy) && $past(tick));
    a_r6_sums_hold_idle: assert property (@(posedge clk) disable iff (rst) !busy && !$rose(busy) |=> busy || ($stable(sum_xy) && $stable(sum_xx)));
    a_r9_holdoff: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> since > CW'(HOLDOFF));
endmodule

bind load_res_est_seq lres_chk #(.SW(2*W+GUARD), .HOLDOFF(HOLDOFF)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .busy          (busy),
    .lvl_force_zero(lvl_force_zero),
    .done          (done),
    .sum_xy        (sum_xy),
    .sum_xx        (sum_xx)
);

// File: tb/sim_load_res_est_seq.sv
`timescale 1ns/1ps
module sim_load_res_est_seq;
    localparam int W  = 16;
    localparam int SW = 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic signed [W-1:0] i_meas = '0;
    logic signed [W-1:0] i_ref  = 16'sd1000;
    logic [W-1:0] ripple_exp = 16'd100;
    logic lvl_force_zero, busy, done;
    logic signed [SW-1:0] sum_xy, sum_xx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    load_res_est_seq u0 (
        .clk(clk), .rst(rst), .tick(tick), .i_meas(i_meas), .i_ref(i_ref),
        .ripple_exp(ripple_exp), .lvl_force_zero(lvl_force_zero), .busy(busy),
        .done(done), .sum_xy(sum_xy), .sum_xx(sum_xx)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one tick with a given measured current, followed by idle cycles
    task automatic do_tick(input int meas, input int gap);
        i_meas = W'(meas);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    // eight episode ticks; s[] land on ticks 2..6; trig kept on other ticks
    task automatic run_episode(input int s0, input int s1, input int s2, input int s3,
                               input int s4, input int fill, input string tag);
        int s [5];
        longint exy, exx;
        s = '{s0, s1, s2, s3, s4};
        exy = 0; exx = 0;
        for (int k = 0; k < 4; k++) begin
            exy += longint'(s[k]) * longint'(s[k+1]);
            exx += longint'(s[k]) * longint'(s[k]);
        end
        for (int t = 1; t <= 8; t++) begin
            do_tick((t >= 2 && t <= 6) ? s[t-2] : fill, 2);
            if (t < 8) begin
                chk(busy && lvl_force_zero, {"R4 busy mid-episode ", tag}, longint'(busy), 1);
                chk(!done, {"R8 no early done ", tag}, longint'(done), 0);
            end
        end
        // do_tick waited 2 idle cycles; done was in the first cycle after the edge
    endtask

    // variant that samples done in the right cycle
    task automatic run_episode_chk(input int s0, input int s1, input int s2, input int s3,
                                   input int s4, input int fill, input string tag);
        int s [5];
        longint exy, exx;
        s = '{s0, s1, s2, s3, s4};
        exy = 0; exx = 0;
        for (int k = 0; k < 4; k++) begin
            exy += longint'(s[k]) * longint'(s[k+1]);
            exx += longint'(s[k]) * longint'(s[k]);
        end
        for (int t = 1; t <= 7; t++) begin
            do_tick((t >= 2 && t <= 6) ? s[t-2] : fill, 2);
            chk(busy && lvl_force_zero, {"R4 busy mid-episode ", tag}, longint'(busy), 1);
            chk(!done, {"R8 no early done ", tag}, longint'(done), 0);
        end
        do_tick(fill, 0);
        chk(done, {"R7 done after eighth tick ", tag}, longint'(done), 1);
        chk(!busy && !lvl_force_zero, {"R4 busy falls ", tag}, longint'(busy), 0);
        chk(longint'(sum_xy) == exy, {"R5 sum_xy ", tag}, longint'(sum_xy), exy);
        chk(longint'(sum_xx) == exx, {"R6 sum_xx ", tag}, longint'(sum_xx), exx);
        @(negedge clk);
        chk(!done, {"R7 done one cycle ", tag}, longint'(done), 0);
        chk(longint'(sum_xy) == exy, {"R6 sums hold ", tag}, longint'(sum_xy), exy);
    endtask

    task automatic t_reset;
        chk(!busy && !lvl_force_zero && !done, "R1 flags low", longint'(busy), 0);
        chk(sum_xy == '0 && sum_xx == '0, "R1 sums zero", longint'(sum_xy), 0);
    endtask

    task automatic t_threshold;
        i_meas = 16'sd1131;
        for (int c = 0; c < 6; c++) @(negedge clk);
        chk(!busy, "R10 no tick no start", longint'(busy), 0);
        do_tick(1130, 1);
        chk(!busy, "R3 equality positive", longint'(busy), 0);
        do_tick(870, 1);
        chk(!busy, "R3 equality negative", longint'(busy), 0);
        do_tick(1000, 1);
        chk(!busy, "R3 zero error", longint'(busy), 0);
        do_tick(1131, 0);
        chk(busy && lvl_force_zero, "R2 start above ratio", longint'(busy), 1);
    endtask

    task automatic t_holdoff;
        for (int h = 0; h < 16; h++) begin
            do_tick(1131, 1);
            chk(!busy, "R9 trigger ignored in hold-off", longint'(busy), 0);
        end
        do_tick(869, 0);
        chk(busy, "R9 R11 start on 17th tick, negative error", longint'(busy), 1);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_threshold();
        run_episode_chk(700, 520, 390, 290, 215, 5000, "R8 positive decay");
        t_holdoff();
        run_episode_chk(-900, -650, -480, -350, -260, -4000, "negative decay");
        // mixed signs and large magnitudes to exercise guard bits
        for (int h = 0; h < 17; h++) do_tick(1131, 1);
        run_episode(1, 1, 1, 1, 1, 0, "fill");
        for (int c = 0; c < 2; c++) @(negedge clk);
        for (int h = 0; h < 16; h++) do_tick(0, 0);
        do_tick(-20000, 0);
        chk(busy, "R11 large negative error", longint'(busy), 1);
        run_episode_chk(32767, -32768, 32767, -32768, 32767, 0, "R5 extremes");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule